// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog timer that escalates through four timeout stages in turn. A tick prescaler divides the bus clock into watchdog ticks. Each stage counts ticks up to its own threshold. When the threshold is reached, the stage performs its own action and hands over to the next stage. After the last stage the sequence starts again at the first. Software restarts the sequence by writing the feed register. If the feed stops, the watchdog steps from a warning interrupt towards a CPU reset and then a system reset, in whatever order the stage actions set.

All writes that change the watchdog's behaviour go through a simple write port. They take effect only while a key register holds the unlock value. The interrupt enable and interrupt clear registers are shared interrupt registers and are always writable. The reset outputs are pulses whose length is configurable. They feed a reset controller outside this block.

Top module: `wdt4_top`

## Requirements
- R1: Writes to the configuration (address 1), the prescaler (2), the feed (3) and the thresholds (4 to 7) are ignored unless the key register (address 0) holds KEY. A write of any other value to address 0 locks again. The interrupt enable (8) and interrupt clear (9) registers are writable at all times.
- R2: After reset all outputs are low, the block is locked and counting is stopped (configuration zero, flash-boot bit at BOOT_RST).
- R3: With prescaler value P at address 2, one watchdog tick occurs every max(P,1) clock cycles.
- R4: Counting starts from a feed write, or from the write that switches counting on. Stage k then expires max(P,1)·(sum over j≤k of max(Tj,1)) cycles after that write's clock edge, where Tj is the threshold at address 4+j. The effect is visible right after that edge.
- R5: Configuration bits [2k+5:2k+4] select the action of stage k: 0 none, 1 interrupt, 2 CPU reset, 3 system reset. An expiry drives only the output its action selects.
- R6: After stage 3 expires, the sequence returns to stage 0 and repeats.
- R7: A feed write returns the sequencer to stage 0 with the tick count and prescaler cleared.
- R8: int_raw sets on an interrupt-action expiry and stays set until a write of 1 to bit 0 of address 9 (a set in the same cycle wins). irq_level is int_raw AND interrupt enable (address 8 bit 0) AND level enable (configuration bit 1).
- R9: irq_edge is a one-cycle pulse on each interrupt-action expiry while the edge enable (configuration bit 2) and the interrupt enable are both set.
- R10: A CPU reset pulse lasts (L+1)·PULSE_UNIT cycles, with L in configuration bits [14:12]. A system reset pulse lasts (L+1)·PULSE_UNIT cycles, with L in bits [17:15].
- R11: Counting runs while the enable bit (configuration bit 0) or the flash-boot bit (bit 3) is set. With both clear, the sequencer and prescaler are held at zero and nothing expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | DW | Register write data |
| irq_level | output | 1 | Level interrupt |
| irq_edge | output | 1 | One-cycle interrupt pulse |
| int_raw | output | 1 | Raw watchdog interrupt status |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
The assertions check on every cycle that the level interrupt never appears without the raw status bit, and that the raw bit holds until a clear write. They also check that an edge pulse always comes with the raw bit, that no tick happens while counting is off, and that a CPU reset and a system reset never start in the same cycle. The exact expiry cycles under each prescaler and threshold pair, the wrap back to stage 0, the pulse lengths and the key lock's refusal of writes can only be shown by the bench's timed scenarios, which compare first-event cycles against arithmetic expectations.

// File: rtl/wdt4_pkg.sv
package wdt4_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } wdt_act_e;

  typedef struct packed {
    logic [2:0] sys_len;
    logic [2:0] cpu_len;
    logic [7:0] acts;
    logic       boot_en;
    logic       edge_en;
    logic       level_en;
    logic       run_en;
  } wdt_cfg_t;

  localparam int CFG_W    = $bits(wdt_cfg_t);
  localparam int NSTAGE   = 4;
  localparam int ADR_KEY  = 0;
  localparam int ADR_CFG  = 1;
  localparam int ADR_PSC  = 2;
  localparam int ADR_FEED = 3;
  localparam int ADR_THR0 = 4;
  localparam int ADR_IEN  = 8;
  localparam int ADR_ICLR = 9;

endpackage

// File: rtl/wdt4_regs.sv
module wdt4_regs
  import wdt4_pkg::*;
#(
  parameter int          AW       = 4,
  parameter int          DW       = 32,
  parameter int          PW       = 16,
  parameter logic [DW-1:0] KEY    = 32'hA5C3_0F96,
  parameter logic        BOOT_RST = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic                  raw_set,
  output wdt_cfg_t              cfg,
  output logic [PW-1:0]         psc,
  output logic [NSTAGE-1:0][DW-1:0] thr,
  output logic                  feed,
  output logic                  int_ena,
  output logic                  int_raw
);

  logic [DW-1:0] key_q;
  logic          unlocked;
  logic          we_key, we_cfg, we_psc, we_ien, we_iclr;
  logic [NSTAGE-1:0] we_thr;
  logic          raw_d;

  always_comb begin
    unlocked = (key_q == KEY);
    we_key   = wr_en && (wr_addr == AW'(ADR_KEY));
    we_cfg   = wr_en && unlocked && (wr_addr == AW'(ADR_CFG));
    we_psc   = wr_en && unlocked && (wr_addr == AW'(ADR_PSC));
    feed     = wr_en && unlocked && (wr_addr == AW'(ADR_FEED));
    we_ien   = wr_en && (wr_addr == AW'(ADR_IEN));
    we_iclr  = wr_en && (wr_addr == AW'(ADR_ICLR));
    if (raw_set)                      raw_d = 1'b1;
    else if (we_iclr && wr_data[0])   raw_d = 1'b0;
    else                              raw_d = int_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q       <= '0;
      cfg         <= '0;
      cfg.boot_en <= BOOT_RST;
      psc         <= '0;
      int_ena     <= 1'b0;
      int_raw     <= 1'b0;
    end else begin
      if (we_key) key_q   <= wr_data;
      if (we_cfg) cfg     <= wdt_cfg_t'(wr_data[CFG_W-1:0]);
      if (we_psc) psc     <= wr_data[PW-1:0];
      if (we_ien) int_ena <= wr_data[0];
      int_raw <= raw_d;
    end
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_thr
    assign we_thr[g] = wr_en && unlocked && (wr_addr == AW'(ADR_THR0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thr[g] <= '0;
      else if (we_thr[g]) thr[g] <= wr_data;
    end
  end

endmodule

// File: rtl/wdt4_tick.sv
module wdt4_tick #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [PW-1:0] psc,
  output logic          tick
);

  logic [PW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = (psc == '0) ? '0 : psc - 1'b1;
    tick  = run && !clr && (cnt_q >= limit);
    if (!run || clr || tick) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt4_seq.sv
module wdt4_seq
  import wdt4_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      clr,
  input  logic                      tick,
  input  logic [NSTAGE-1:0][DW-1:0] thr,
  input  logic [2*NSTAGE-1:0]       acts,
  output logic                      expire,
  output wdt_act_e                  exp_act
);

  localparam int SW = $clog2(NSTAGE);

  logic [SW-1:0] stg_q, stg_d;
  logic [DW-1:0] cnt_q, cnt_d, cur_thr, last;

  always_comb begin
    cur_thr = thr[stg_q];
    last    = (cur_thr == '0) ? '0 : cur_thr - 1'b1;
    expire  = tick && (cnt_q >= last);
    exp_act = wdt_act_e'(acts[2*stg_q +: 2]);
    stg_d   = stg_q;
    cnt_d   = cnt_q;
    if (!run || clr) begin
      stg_d = '0;
      cnt_d = '0;
    end else if (expire) begin
      stg_d = stg_q + 1'b1;
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      cnt_q <= '0;
    end else begin
      stg_q <= stg_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/wdt4_stretch.sv
module wdt4_stretch #(
  parameter int UNIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] len,
  output logic       pulse
);

  localparam int MAXL = 8 * UNIT;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start)             cnt_d = CW'((32'(len) + 1) * UNIT);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
    pulse = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt4_top.sv
module wdt4_top
  import wdt4_pkg::*;
#(
  parameter int            AW         = 4,
  parameter int            DW         = 32,
  parameter int            PW         = 16,
  parameter logic [DW-1:0] KEY        = 32'hA5C3_0F96,
  parameter int            PULSE_UNIT = 8,
  parameter logic          BOOT_RST   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          irq_level,
  output logic          irq_edge,
  output logic          int_raw,
  output logic          cpu_rst,
  output logic          sys_rst
);

  logic [1:0]                rst_sync_q;
  logic                      rst_n_s;
  wdt_cfg_t                  cfg;
  logic [PW-1:0]             psc;
  logic [NSTAGE-1:0][DW-1:0] thr;
  logic                      feed, int_ena, run, tick, expire, raw_set, edge_d, edge_q;
  wdt_act_e                  exp_act;
  logic [1:0]                rst_start;
  logic [1:0][2:0]           rst_len;
  logic [1:0]                rst_pulse;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wdt4_regs #(.AW(AW), .DW(DW), .PW(PW), .KEY(KEY), .BOOT_RST(BOOT_RST)) u_regs (
    .clk, .rst_n(rst_n_s), .wr_en, .wr_addr, .wr_data, .raw_set,
    .cfg, .psc, .thr, .feed, .int_ena, .int_raw
  );

  assign run = cfg.run_en | cfg.boot_en;

  wdt4_tick #(.PW(PW)) u_tick (
    .clk, .rst_n(rst_n_s), .run, .clr(feed), .psc, .tick
  );

  wdt4_seq #(.DW(DW)) u_seq (
    .clk, .rst_n(rst_n_s), .run, .clr(feed), .tick, .thr, .acts(cfg.acts),
    .expire, .exp_act
  );

  always_comb begin
    raw_set      = expire && (exp_act == ACT_IRQ);
    edge_d       = raw_set && cfg.edge_en && int_ena;
    rst_start[0] = expire && (exp_act == ACT_CPU);
    rst_start[1] = expire && (exp_act == ACT_SYS);
    rst_len[0]   = cfg.cpu_len;
    rst_len[1]   = cfg.sys_len;
    irq_level    = int_raw && int_ena && cfg.level_en;
    irq_edge     = edge_q;
    cpu_rst      = rst_pulse[0];
    sys_rst      = rst_pulse[1];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) edge_q <= 1'b0;
    else          edge_q <= edge_d;
  end

  for (genvar g = 0; g < 2; g++) begin : g_rst
    wdt4_stretch #(.UNIT(PULSE_UNIT)) u_stretch (
      .clk, .rst_n(rst_n_s), .start(rst_start[g]), .len(rst_len[g]), .pulse(rst_pulse[g])
    );
  end

endmodule

// File: rtl/wdt4_chk.sv
module wdt4_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_wr,
  input logic run,
  input logic tick,
  input logic int_raw,
  input logic irq_level,
  input logic irq_edge,
  input logic cpu_rst,
  input logic sys_rst
);

  p_level_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> int_raw);

  p_raw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_raw && !clr_wr) |=> int_raw);

  p_edge_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge |-> int_raw);

  p_idle_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  p_one_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> !$rose(sys_rst));

endmodule

bind wdt4_top wdt4_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .clr_wr    (wr_en && (wr_addr == AW'(wdt4_pkg::ADR_ICLR)) && wr_data[0]),
  .run       (run),
  .tick      (tick),
  .int_raw   (int_raw),
  .irq_level (irq_level),
  .irq_edge  (irq_edge),
  .cpu_rst   (cpu_rst),
  .sys_rst   (sys_rst)
);

// File: tb/wdt4_top_test.sv
`timescale 1ns/1ps
module wdt4_top_test;

  localparam logic [31:0] KEY  = 32'hA5C3_0F96;
  localparam int          UNIT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        irq_level, irq_edge, int_raw, cpu_rst, sys_rst;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int t_int, t_edge, t_lvl, t_cpu, t_sys, c_edge, c_cpu, c_sys;

  always #5 clk = ~clk;

  wdt4_top #(.PULSE_UNIT(UNIT)) uut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .irq_level, .irq_edge, .int_raw, .cpu_rst, .sys_rst
  );

  function automatic logic [31:0] mk_cfg(bit en, bit lvl, bit edg, bit boot,
                                         logic [7:0] acts, logic [2:0] cl, logic [2:0] sl);
    return {14'd0, sl, cl, acts, boot, edg, lvl, en};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic watch(input int n);
    t_int = -1; t_edge = -1; t_lvl = -1; t_cpu = -1; t_sys = -1;
    c_edge = 0; c_cpu = 0; c_sys = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); #1;
      if (int_raw   && t_int  < 0) t_int  = i;
      if (irq_edge  && t_edge < 0) t_edge = i;
      if (irq_level && t_lvl  < 0) t_lvl  = i;
      if (cpu_rst   && t_cpu  < 0) t_cpu  = i;
      if (sys_rst   && t_sys  < 0) t_sys  = i;
      if (irq_edge) c_edge++;
      if (cpu_rst)  c_cpu++;
      if (sys_rst)  c_sys++;
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R2 reset state
    check({irq_level, irq_edge, int_raw, cpu_rst, sys_rst} == 5'b0, "R2", "outputs after reset",
          int'({irq_level, irq_edge, int_raw, cpu_rst, sys_rst}), 0);

    // R1: locked from reset, enable write ignored (zero thresholds would fire at once)
    wr(4'd8, 32'd1);
    wr(4'd1, mk_cfg(1, 1, 1, 0, 8'h01, 0, 0));
    watch(40);
    check(t_int == -1, "R1", "locked config write took effect", t_int, -1);

    // unlock, sweep prescaler and stage-0 threshold (R3, R4, R8, R9)
    wr(4'd0, KEY);
    for (int s = 1; s < 4; s++) wr(4'(4 + s), 32'd100);
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 4; t++) begin
        int exp;
        wr(4'd1, mk_cfg(0, 1, 1, 0, 8'h01, 0, 0));
        wr(4'd2, 32'(p));
        wr(4'd4, 32'(t));
        wr(4'd9, 32'd1);
        wr(4'd1, mk_cfg(1, 1, 1, 0, 8'h01, 0, 0));
        watch(12);
        exp = (p < 1 ? 1 : p) * (t < 1 ? 1 : t);
        check(t_int == exp, "R3", $sformatf("stage0 expiry p=%0d t=%0d", p, t), t_int, exp);
        check(t_edge == exp && c_edge == 1, "R9", $sformatf("edge pulse p=%0d t=%0d", p, t), t_edge, exp);
        check(t_lvl == exp, "R8", $sformatf("level irq p=%0d t=%0d", p, t), t_lvl, exp);
      end
    end

    // R4 R5 R6 R10: actions none, irq, cpu, sys with thresholds 2,3,1,2
    wr(4'd1, mk_cfg(0, 1, 1, 0, 8'b11_10_01_00, 3'd1, 3'd0));
    wr(4'd2, 32'd1);
    wr(4'd4, 32'd2); wr(4'd5, 32'd3); wr(4'd6, 32'd1); wr(4'd7, 32'd2);
    wr(4'd9, 32'd1);
    wr(4'd1, mk_cfg(1, 1, 1, 0, 8'b11_10_01_00, 3'd1, 3'd0));
    watch(13);
    check(t_int == 5, "R4", "cumulative stage1 irq", t_int, 5);
    check(t_cpu == 6, "R5", "stage2 cpu reset start", t_cpu, 6);
    check(t_sys == 8, "R5", "stage3 sys reset start", t_sys, 8);
    check(c_edge == 2, "R6", "irq after wrap count", c_edge, 2);
    check(c_cpu == 4, "R10", "cpu pulse len L=1", c_cpu, 4);
    check(c_sys == 2, "R10", "sys pulse len L=0", c_sys, 2);

    // R10 long pulses, R5 with sys on stage0 and cpu on stage2
    wr(4'd1, mk_cfg(0, 1, 1, 0, 8'b00_10_00_11, 3'd7, 3'd3));
    wr(4'd7, 32'd20);
    wr(4'd9, 32'd1);
    wr(4'd1, mk_cfg(1, 1, 1, 0, 8'b00_10_00_11, 3'd7, 3'd3));
    watch(27);
    check(t_sys == 2 && t_int == -1, "R5", "stage0 sys only", t_sys, 2);
    check(t_cpu == 6, "R5", "stage2 cpu start", t_cpu, 6);
    check(c_cpu == 16, "R10", "cpu pulse len L=7", c_cpu, 16);
    check(c_sys == 8, "R10", "sys pulse len L=3", c_sys, 8);

    // R7 feed restarts stage 0
    wr(4'd1, mk_cfg(0, 1, 1, 0, 8'h01, 0, 0));
    wr(4'd4, 32'd10); wr(4'd5, 32'd5); wr(4'd6, 32'd5); wr(4'd7, 32'd5);
    wr(4'd9, 32'd1);
    wr(4'd1, mk_cfg(1, 1, 1, 0, 8'h01, 0, 0));
    watch(6);
    check(t_int == -1, "R7", "no irq before feed", t_int, -1);
    wr(4'd3, 32'd1);
    watch(15);
    check(t_int == 10, "R7", "expiry counted from feed", t_int, 10);

    // R11 flash-boot bit alone runs; R8 enable gating; R9 edge disabled
    wr(4'd1, mk_cfg(0, 1, 0, 0, 8'h01, 0, 0));
    wr(4'd4, 32'd3); wr(4'd5, 32'd50); wr(4'd6, 32'd50); wr(4'd7, 32'd50);
    wr(4'd8, 32'd0);
    wr(4'd9, 32'd1);
    wr(4'd1, mk_cfg(0, 1, 0, 1, 8'h01, 0, 0));
    watch(10);
    check(t_int == 3, "R11", "boot bit runs watchdog", t_int, 3);
    check(t_lvl == -1, "R8", "level masked by int enable", t_lvl, -1);
    check(t_edge == -1, "R9", "edge masked by edge enable", t_edge, -1);
    wr(4'd8, 32'd1);
    check(irq_level == 1'b1, "R8", "level after enable", int'(irq_level), 1);
    check(irq_edge == 1'b0, "R9", "no edge from late enable", int'(irq_edge), 0);
    wr(4'd9, 32'd1);
    check(int_raw == 1'b0 && irq_level == 1'b0, "R8", "clear write", int'(int_raw), 0);

    // R1 relock: disable ignored while locked or wrong key
    wr(4'd1, mk_cfg(0, 1, 1, 0, 8'h01, 0, 0));
    wr(4'd4, 32'd3); wr(4'd5, 32'd5); wr(4'd6, 32'd5); wr(4'd7, 32'd5);
    wr(4'd1, mk_cfg(1, 1, 1, 0, 8'h01, 0, 0));
    wr(4'd0, 32'd0);
    wr(4'd1, mk_cfg(0, 1, 1, 0, 8'h01, 0, 0));
    wr(4'd9, 32'd1);
    watch(25);
    check(t_int > 0, "R1", "disable ignored after relock", t_int, 1);
    wr(4'd0, KEY ^ 32'd1);
    wr(4'd1, mk_cfg(0, 1, 1, 0, 8'h01, 0, 0));
    wr(4'd9, 32'd1);
    watch(25);
    check(t_int > 0, "R1", "disable ignored with wrong key", t_int, 1);
    wr(4'd0, KEY);
    wr(4'd1, mk_cfg(0, 1, 1, 0, 8'h01, 0, 0));
    wr(4'd9, 32'd1);
    watch(40);
    check(t_int == -1 && c_cpu == 0 && c_sys == 0, "R11", "stopped when both run bits clear", t_int, -1);

    done = 1'b1;
    finish_run();
  end

endmodule